// File: doc/BRIEF.md
# Deferred Condition Flag Reconstructor

This block rebuilds the four processor condition flags (negative, zero, carry, overflow) on demand. It does not take the flags themselves. It takes a compact record of the last flag-setting operation: a 4-bit operation code and three 32-bit operand words. The meaning of each operand word depends on the operation. For arithmetic the words carry the original operands, so the block recomputes the sum or difference only to obtain the flags. For the other operations the words carry a result and the flag bits that the operation leaves unchanged.

The unit is purely combinational. It drives four outputs:
- the flags packed into the top nibble of a 32-bit word;
- the carry flag alone, in bit 0 of its own word;
- the overflow flag alone, in bit 0 of its own word;
- a single-bit verdict for a requested 4-bit condition code.

The condition code and the operation code arrive together on one 8-bit request input. The condition sits in the upper nibble and the operation in the lower nibble.

Top module: `lazy_flag_eval`

## Requirements
- R1: `nzcv_word` carries N, Z, C, V in bits 31, 30, 29, 28 and zero in bits 27:0. `carry_word` and `ovf_word` hold C and V in bit 0 and zero in all other bits.
- R2: For operation 0 (copy), the four flags equal `dep_a[31:28]`, bit for bit.
- R3: For operation 1 (add), the result is `dep_a + dep_b`. N is result bit 31 and Z is set when the 32-bit result is zero. C is the unsigned carry out and V is the signed overflow.
- R4: For operation 2 (subtract), the result is `dep_a - dep_b`. C is 1 exactly when `dep_a >= dep_b` unsigned. V is the signed overflow. N and Z are taken from the result.
- R5: For operation 3 (add with carry), the result is `dep_a + dep_b + dep_c[0]`. C and V are the unsigned carry and signed overflow of that sum, and N and Z come from its result.
- R6: For operation 4 (subtract with carry), the result is `dep_a - dep_b - (1 - dep_c[0])`. C is 1 when no borrow occurs and V is the signed overflow. N and Z are taken from the result.
- R7: For operation 5 (logic), N and Z come from `dep_a`, C is `dep_b[0]` and V is `dep_c[0]`.
- R8: For operation 6 (multiply), N and Z come from `dep_a`, C is `dep_c[1]` and V is `dep_c[0]`.
- R9: For operation 7 (long multiply), the 64-bit product is `{dep_b, dep_a}`. N is its bit 63 and Z is set only when all 64 bits are zero. C is `dep_c[1]` and V is `dep_c[0]`.
- R10: `cond_hit` evaluates `req_sel[7:4]` against the flags as follows:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C & !Z
  - 9: !C | Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z & N==V
  - 13: Z | N!=V
- R11: Condition 14 always gives 1 and condition 15 always gives 0, whatever the operation and operands.
- R12: Operation codes 8 to 15 give all-zero flags on every output. Conditions then evaluate from zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_sel | input | 8 | [7:4] condition code, [3:0] operation code |
| dep_a | input | 32 | First operand word |
| dep_b | input | 32 | Second operand word |
| dep_c | input | 32 | Third operand word (old carry / old overflow bits) |
| nzcv_word | output | 32 | Flags in bits 31:28, zero below |
| carry_word | output | 32 | C in bit 0 |
| ovf_word | output | 32 | V in bit 0 |
| cond_hit | output | 1 | Verdict for the requested condition |

## Verification
The bench builds the block with its default 32-bit word, the only width the flag layout defines. At that width, random operands reach the carry and overflow boundaries only rarely, so the bench adds directed cases that sit on them:
- 0x7FFFFFFF + 1;
- 0x80000000 - 1;
- equal operands;
- all-ones plus carry-in;
- a long-multiply product whose only set bit lies in the high word.

Random requests sweep all 16 operation codes against all 16 conditions. Every undefined operation code is therefore paired with every condition, including always and never.

// File: rtl/lfe_pkg.sv
package lfe_pkg;

    localparam int WORD_W = 32;
    localparam int CODE_W = 4;
    localparam int REQ_W  = 2 * CODE_W;

    typedef enum logic [CODE_W-1:0] {
        OP_COPY  = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_ADC   = 4'd3,
        OP_SBB   = 4'd4,
        OP_LOGIC = 4'd5,
        OP_MUL   = 4'd6,
        OP_MULL  = 4'd7
    } op_e;

    typedef enum logic [CODE_W-1:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam flags_t FLAGS_ZERO = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    function automatic logic is_arith(input logic [CODE_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADC) || (op == OP_SBB);
    endfunction

endpackage

// File: rtl/lfe_arith.sv
module lfe_arith
    import lfe_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [CODE_W-1:0] op,
    input  logic [W-1:0]      lhs,
    input  logic [W-1:0]      rhs,
    input  logic              old_c,
    output flags_t            fl
);
    localparam int EW = W + 1;

    logic          invert;
    logic          cin;
    logic [W-1:0]  rhs_eff;
    logic [EW-1:0] sum_ext;
    logic [W-1:0]  res;

    always_comb begin
        invert  = (op == OP_SUB) || (op == OP_SBB);
        unique case (op)
            OP_SUB:         cin = 1'b1;
            OP_ADC, OP_SBB: cin = old_c;
            default:        cin = 1'b0;
        endcase
        rhs_eff = invert ? ~rhs : rhs;
        sum_ext = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, cin};
        res     = sum_ext[W-1:0];
        fl.n    = res[W-1];
        fl.z    = (res == '0);
        fl.c    = sum_ext[W];
        fl.v    = (lhs[W-1] == rhs_eff[W-1]) && (res[W-1] != lhs[W-1]);
    end

endmodule

// File: rtl/lfe_misc.sv
module lfe_misc
    import lfe_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [CODE_W-1:0] op,
    input  logic [W-1:0]      word_a,
    input  logic [W-1:0]      word_b,
    input  logic [1:0]        kept_cv,
    output flags_t            fl
);
    localparam int TOP = W - 1;

    logic lo_zero;
    logic hi_zero;

    always_comb begin
        lo_zero = (word_a == '0);
        hi_zero = (word_b == '0);
        fl      = FLAGS_ZERO;
        unique case (op)
            OP_COPY: begin
                fl.n = word_a[TOP];
                fl.z = word_a[TOP-1];
                fl.c = word_a[TOP-2];
                fl.v = word_a[TOP-3];
            end
            OP_LOGIC: begin
                fl.n = word_a[TOP];
                fl.z = lo_zero;
                fl.c = word_b[0];
                fl.v = kept_cv[0];
            end
            OP_MUL: begin
                fl.n = word_a[TOP];
                fl.z = lo_zero;
                fl.c = kept_cv[1];
                fl.v = kept_cv[0];
            end
            OP_MULL: begin
                fl.n = word_b[TOP];
                fl.z = lo_zero && hi_zero;
                fl.c = kept_cv[1];
                fl.v = kept_cv[0];
            end
            default: fl = FLAGS_ZERO;
        endcase
    end

endmodule

// File: rtl/lfe_cond.sv
module lfe_cond
    import lfe_pkg::*;
(
    input  logic [CODE_W-1:0] cond,
    input  flags_t            fl,
    output logic              hit
);
    logic base;
    logic nv_eq;

    // Even codes hold the base test; the odd code above each one inverts it.
    // The final pair (always/never) fits the same scheme with base = 1.
    always_comb begin
        nv_eq = (fl.n == fl.v);
        unique case (cond[3:1])
            3'd0:    base = fl.z;
            3'd1:    base = fl.c;
            3'd2:    base = fl.n;
            3'd3:    base = fl.v;
            3'd4:    base = fl.c && !fl.z;
            3'd5:    base = nv_eq;
            3'd6:    base = !fl.z && nv_eq;
            default: base = 1'b1;
        endcase
        hit = cond[0] ? !base : base;
    end

    always_comb begin
        // R11
        always_true_chk: assert (!(cond == CC_AL) || hit);
        // R11
        never_true_chk: assert (!(cond == CC_NV) || !hit);
    end

endmodule

// File: rtl/lazy_flag_eval.sv
module lazy_flag_eval
    import lfe_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [REQ_W-1:0] req_sel,
    input  logic [W-1:0]     dep_a,
    input  logic [W-1:0]     dep_b,
    input  logic [W-1:0]     dep_c,
    output logic [W-1:0]     nzcv_word,
    output logic [W-1:0]     carry_word,
    output logic [W-1:0]     ovf_word,
    output logic             cond_hit
);
    localparam int FLAG_N = 4;

    logic [CODE_W-1:0] op_code;
    logic [CODE_W-1:0] cond_code;
    logic              op_known;
    flags_t            fl_arith;
    flags_t            fl_misc;
    flags_t            fl_sel;
    logic              unused_hi;

    assign op_code   = req_sel[CODE_W-1:0];
    assign cond_code = req_sel[REQ_W-1:CODE_W];
    assign op_known  = (op_code[CODE_W-1] == 1'b0);
    assign unused_hi = ^dep_c[W-1:2];

    lfe_arith #(.W(W)) u_arith (
        .op    (op_code),
        .lhs   (dep_a),
        .rhs   (dep_b),
        .old_c (dep_c[0]),
        .fl    (fl_arith)
    );

    lfe_misc #(.W(W)) u_misc (
        .op      (op_code),
        .word_a  (dep_a),
        .word_b  (dep_b),
        .kept_cv (dep_c[1:0]),
        .fl      (fl_misc)
    );

    always_comb begin
        if (!op_known)
            fl_sel = FLAGS_ZERO;
        else if (is_arith(op_code))
            fl_sel = fl_arith;
        else
            fl_sel = fl_misc;
    end

    lfe_cond u_cond (
        .cond (cond_code),
        .fl   (fl_sel),
        .hit  (cond_hit)
    );

    assign nzcv_word  = {fl_sel, {(W-FLAG_N){1'b0}}};
    assign carry_word = {{(W-1){1'b0}}, fl_sel.c};
    assign ovf_word   = {{(W-1){1'b0}}, fl_sel.v};

    always_comb begin
        // R12
        undef_zero_chk: assert (op_known || nzcv_word == '0);
        // R2
        copy_pass_chk: assert (!(op_code == OP_COPY) || nzcv_word[W-1:W-FLAG_N] == dep_a[W-1:W-FLAG_N]);
        // R7
        logic_cv_chk: assert (!(op_code == OP_LOGIC) || (carry_word[0] == dep_b[0] && ovf_word[0] == dep_c[0]));
        // R8
        mul_keep_chk: assert (!(op_code == OP_MUL || op_code == OP_MULL) || (carry_word[0] == dep_c[1] && ovf_word[0] == dep_c[0]));
        // R1
        split_match_chk: assert (carry_word[0] == nzcv_word[W-3] && ovf_word[0] == nzcv_word[W-4]);
    end

endmodule

// File: tb/sim_lazy_flag_eval.sv
module sim_lazy_flag_eval;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_sel = '0;
    logic [31:0] dep_a = '0, dep_b = '0, dep_c = '0;
    logic [31:0] nzcv_word, carry_word, ovf_word;
    logic        cond_hit;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    lazy_flag_eval u0 (
        .req_sel(req_sel), .dep_a(dep_a), .dep_b(dep_b), .dep_c(dep_c),
        .nzcv_word(nzcv_word), .carry_word(carry_word), .ovf_word(ovf_word),
        .cond_hit(cond_hit)
    );

    function automatic logic ovf_of(input longint s);
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    // Expected flags {N,Z,C,V}.
    function automatic logic [3:0] model_flags(input logic [3:0] op, input logic [31:0] a,
                                               input logic [31:0] b, input logic [31:0] c);
        longint sa, sb, ss;
        logic [63:0] ua, ub, us;
        logic [31:0] r;
        logic ci;
        ci = c[0];
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        ua = {32'd0, a};
        ub = {32'd0, b};
        case (op)
            4'd0: return a[31:28];
            4'd1: begin us = ua + ub; ss = sa + sb; r = us[31:0];
                        return {r[31], r == 0, us[32], ovf_of(ss)}; end
            4'd2: begin ss = sa - sb; r = a - b;
                        return {r[31], r == 0, ua >= ub, ovf_of(ss)}; end
            4'd3: begin us = ua + ub + 64'(ci); ss = sa + sb + longint'(ci); r = us[31:0];
                        return {r[31], r == 0, us[32], ovf_of(ss)}; end
            4'd4: begin ss = sa - sb - longint'(!ci); r = a - b - 32'(!ci);
                        return {r[31], r == 0, ua >= ub + 64'(!ci), ovf_of(ss)}; end
            4'd5: return {a[31], a == 0, b[0], c[0]};
            4'd6: return {a[31], a == 0, c[1], c[0]};
            4'd7: return {b[31], {b, a} == 64'd0, c[1], c[0]};
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic model_cond(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (cc)
            4'd0: return z;            4'd1: return !z;
            4'd2: return cy;           4'd3: return !cy;
            4'd4: return n;            4'd5: return !n;
            4'd6: return v;            4'd7: return !v;
            4'd8: return cy && !z;     4'd9: return !cy || z;
            4'd10: return n == v;      4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R4";
            4'd3: return "R5";  4'd4: return "R6";  4'd5: return "R7";
            4'd6: return "R8";  4'd7: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s req=%02h a=%08h b=%08h c=%08h actual=%08h expected=%08h",
                     tag, req_sel, dep_a, dep_b, dep_c, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] cc, input logic [3:0] op,
                         input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
        logic [3:0] f;
        @(posedge clk);
        req_sel = {cc, op};
        dep_a = a; dep_b = b; dep_c = c;
        f = model_flags(op, a, b, c);
        @(negedge clk);
        check32(op_tag(op), nzcv_word, {f, 28'd0});
        check32("R1 carry", carry_word, {31'd0, f[1]});
        check32("R1 ovf", ovf_word, {31'd0, f[0]});
        check32((cc >= 4'd14) ? "R11" : "R10", {31'd0, cond_hit}, {31'd0, model_cond(cc, f)});
    endtask

    function automatic logic [31:0] pick(input int sel);
        case (sel % 6)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-like state: all-zero request gives EQ on copy of zero.
        apply(4'd0, 4'd0, 32'd0, 32'd0, 32'd0);
        // R2 copy
        apply(4'd4, 4'd0, 32'hA000_0000, 32'd0, 32'd0);
        apply(4'd10, 4'd0, 32'h5FFF_FFFF, 32'd0, 32'd0);
        // R3 add boundaries
        apply(4'd6, 4'd1, 32'h7FFF_FFFF, 32'd1, 32'd0);
        apply(4'd2, 4'd1, 32'hFFFF_FFFF, 32'd1, 32'd0);
        // R4 subtract equal / borrow
        apply(4'd0, 4'd2, 32'h1234_5678, 32'h1234_5678, 32'd0);
        apply(4'd3, 4'd2, 32'd1, 32'd2, 32'd0);
        apply(4'd6, 4'd2, 32'h8000_0000, 32'd1, 32'd0);
        // R5 add with carry
        apply(4'd0, 4'd3, 32'hFFFF_FFFF, 32'd0, 32'd1);
        apply(4'd6, 4'd3, 32'h7FFF_FFFF, 32'd0, 32'd1);
        // R6 subtract with carry
        apply(4'd2, 4'd4, 32'd5, 32'd5, 32'd0);
        apply(4'd0, 4'd4, 32'd5, 32'd5, 32'd1);
        // R7 logic, R8 multiply
        apply(4'd2, 4'd5, 32'd0, 32'd1, 32'd1);
        apply(4'd6, 4'd6, 32'h8000_0000, 32'd0, 32'd2);
        // R9 long multiply: high word only / all zero
        apply(4'd0, 4'd7, 32'd0, 32'h0000_0001, 32'd3);
        apply(4'd0, 4'd7, 32'd0, 32'd0, 32'd0);
        apply(4'd4, 4'd7, 32'd0, 32'h8000_0000, 32'd0);
        // R11 / R12
        for (int op = 8; op < 16; op++)
            for (int cc = 0; cc < 16; cc++)
                apply(4'(cc), 4'(op), $urandom, $urandom, $urandom);
        // Random sweep
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            ra = pick($urandom % 7);
            rb = ($urandom % 5 == 0) ? ra : pick($urandom % 7);
            apply(4'($urandom), 4'($urandom), ra, rb, $urandom % 4);
        end
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule